// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialisation Scheduler

This block keeps a 512-row dynamic memory alive. It uses refresh cycles in which the column strobe falls before the row strobe. The memory then picks the row from its own internal counter, so the scheduler never drives an address. After reset it first waits a long power-up pause. It then runs eight refresh cycles before it declares the memory usable. After that, a periodic timer owes one refresh every `REF_INTERVAL` clocks, which spreads 512 refreshes evenly over the retention period.

Each refresh needs the memory bus, so the scheduler raises `bus_req` and waits for `bus_grant` from the access controller. Once granted, it drives the row strobe, the column strobes and the write enable itself. It releases the request only after the row precharge time has elapsed. Refreshes that fall due while the grant is withheld are counted, up to `OWED_MAX`, and are then issued back to back.

A pulse on `clk_lapse` tells the block that the memory has gone unclocked for longer than the retention period. The block then drops `init_done` and repeats the eight start-up cycles, without the power-up pause. Host traffic is allowed only while `init_done` is high.

The top-level controller has four states:
- TOP_PAUSE moves to TOP_IDLE when the pause counter expires.
- TOP_IDLE moves to TOP_REQ when an initialisation cycle or a periodic refresh is owed.
- TOP_REQ moves to TOP_BUSY when the grant is seen. On that same edge it starts the strobe sequencer.
- TOP_BUSY moves to TOP_IDLE when the sequencer reports the end of precharge.

The strobe sequencer runs SEQ_IDLE → SEQ_CAS → SEQ_RAS → SEQ_HOLD → SEQ_PRE → SEQ_IDLE:
- SEQ_CAS: column low, row high, for `T_CSR` clocks.
- SEQ_RAS: both strobes low, for `T_CHR` clocks.
- SEQ_HOLD: row low, column high, for `T_RAS - T_CHR` clocks.
- SEQ_PRE: both strobes high, for `T_RP` clocks.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, `ras_n`, every `cas_n` lane and `we_n` are 1, and `bus_req` and `init_done` are 0.
- R2: After reset is released, `bus_req` stays 0 and `ras_n` stays 1 for at least `INIT_PAUSE` clocks. The first request appears no more than 3 clocks after that.
- R3: After the pause, exactly 8 refresh cycles are issued. `init_done` then rises in the clock after the last precharge, with `bus_req` already 0.
- R4: In every refresh, all `cas_n` lanes fall together and stay low for exactly `T_CSR` clocks before `ras_n` falls. They remain low for exactly `T_CHR` clocks after that, and `ras_n` stays low for exactly `T_RAS` clocks.
- R5: `we_n` is 1 at all times, so every cycle the block issues is a refresh and never a write.
- R6: Strobes start only when `bus_grant` was 1 in the clock before. While the grant is withheld, `bus_req` stays 1 and `ras_n` stays 1.
- R7: After each refresh, `ras_n` stays 1 for exactly `T_RP` clocks with `bus_req` still 1. `bus_req` then falls.
- R8: Once `init_done` is 1 and the grant is held at 1, successive falling edges of `ras_n` are exactly `REF_INTERVAL` clocks apart.
- R9: While the grant is withheld, owed refreshes accumulate up to `OWED_MAX`, and any beyond that are dropped. When the grant returns, the owed count is issued back to back.
- R10: A one-clock pulse on `clk_lapse` clears `init_done` on the next clock. The first of 8 new refresh cycles starts within 6 clocks, with no pause. `init_done` returns to 1 after the eighth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_lapse | input | 1 | Pulse: memory has been left unclocked beyond the retention period |
| bus_grant | input | 1 | Memory bus granted to the scheduler |
| bus_req | output | 1 | Memory bus requested by the scheduler |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | LANES | Column strobes, one per byte lane, active low |
| we_n | output | 1 | Write enable, held high |
| init_done | output | 1 | Memory initialised; host access allowed |

## Verification
A wrong sequencer state shows at the strobes within the same refresh. A phase that is one clock too short or too long changes the column lead, the row-low width or the precharge length, and the checks measure each of these on every refresh. A wrong timer or owed count shows within one refresh interval: the spacing between row-strobe falls changes, or the number of refreshes issued after a starved window differs from the number owed. A wrong initialisation counter shows the moment `init_done` rises, because the refresh count issued up to that point is not eight.

// File: rtl/drs_pkg.sv
`timescale 1ns/1ps
package drs_pkg;

    localparam int INIT_CYCLES = 8;
    localparam int IW          = $clog2(INIT_CYCLES + 1);

    typedef enum logic [1:0] {
        TOP_PAUSE,
        TOP_IDLE,
        TOP_REQ,
        TOP_BUSY
    } top_st_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_CAS,
        SEQ_RAS,
        SEQ_HOLD,
        SEQ_PRE
    } seq_st_t;

endpackage

// File: rtl/drs_interval_timer.sv
`timescale 1ns/1ps
module drs_interval_timer #(
    parameter int REF_INTERVAL = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(REF_INTERVAL + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= TW'(REF_INTERVAL - 1);
        end else if (cnt == '0) begin
            cnt <= TW'(REF_INTERVAL - 1);
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = en && (cnt == '0);
endmodule

// File: rtl/drs_owed_counter.sv
`timescale 1ns/1ps
module drs_owed_counter #(
    parameter int OWED_MAX = 8,
    localparam int OW = $clog2(OWED_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [OW-1:0] count,
    output logic          pending
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10: if (count < OW'(OWED_MAX)) count <= count + 1'b1;
                2'b01: if (count != '0) count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign pending = (count != '0);
endmodule

// File: rtl/drs_cbr_sequencer.sv
`timescale 1ns/1ps
module drs_cbr_sequencer
    import drs_pkg::*;
#(
    parameter int T_CSR = 2,
    parameter int T_CHR = 1,
    parameter int T_RAS = 4,
    parameter int T_RP  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ras_n,
    output logic cas_n,
    output logic done
);
    localparam int CW = $clog2(T_CSR + T_RAS + T_RP + 1);

    seq_st_t       st, st_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SEQ_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        cnt_nxt = (cnt == '0) ? cnt : cnt - 1'b1;
        unique case (st)
            SEQ_IDLE: if (start) begin
                st_nxt  = SEQ_CAS;
                cnt_nxt = CW'(T_CSR - 1);
            end
            SEQ_CAS: if (cnt == '0) begin
                st_nxt  = SEQ_RAS;
                cnt_nxt = CW'(T_CHR - 1);
            end
            SEQ_RAS: if (cnt == '0) begin
                st_nxt  = SEQ_HOLD;
                cnt_nxt = CW'(T_RAS - T_CHR - 1);
            end
            SEQ_HOLD: if (cnt == '0) begin
                st_nxt  = SEQ_PRE;
                cnt_nxt = CW'(T_RP - 1);
            end
            SEQ_PRE: if (cnt == '0) begin
                st_nxt  = SEQ_IDLE;
                cnt_nxt = '0;
            end
            default: st_nxt = SEQ_IDLE;
        endcase
    end

    always_comb begin
        ras_n = !((st == SEQ_RAS) || (st == SEQ_HOLD));
        cas_n = !((st == SEQ_CAS) || (st == SEQ_RAS));
        done  = (st == SEQ_PRE) && (cnt == '0);
    end
endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched
    import drs_pkg::*;
#(
    parameter int INIT_PAUSE   = 25000,
    parameter int REF_INTERVAL = 1950,
    parameter int OWED_MAX     = 8,
    parameter int T_CSR        = 2,
    parameter int T_CHR        = 1,
    parameter int T_RAS        = 4,
    parameter int T_RP         = 4,
    parameter int LANES        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_lapse,
    input  logic             bus_grant,
    output logic             bus_req,
    output logic             ras_n,
    output logic [LANES-1:0] cas_n,
    output logic             we_n,
    output logic             init_done
);
    localparam int PW = $clog2(INIT_PAUSE + 1);
    localparam int OW = $clog2(OWED_MAX + 1);

    top_st_t       state, state_nxt;
    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] init_left;
    logic          is_init;
    logic          start, seq_done, seq_ras_n, seq_cas_n;
    logic          tick, owed_pend, owed_dec;
    logic [OW-1:0] owed;

    drs_interval_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
        .clk (clk), .rst_n (rst_n), .en (init_done), .tick (tick)
    );

    drs_owed_counter #(.OWED_MAX(OWED_MAX)) u_owed (
        .clk (clk), .rst_n (rst_n), .inc (tick), .dec (owed_dec),
        .count (owed), .pending (owed_pend)
    );

    drs_cbr_sequencer #(
        .T_CSR (T_CSR), .T_CHR (T_CHR), .T_RAS (T_RAS), .T_RP (T_RP)
    ) u_seq (
        .clk (clk), .rst_n (rst_n), .start (start),
        .ras_n (seq_ras_n), .cas_n (seq_cas_n), .done (seq_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TOP_PAUSE;
        end else begin
            state <= state_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            TOP_PAUSE: if (pause_cnt == '0)                   state_nxt = TOP_IDLE;
            TOP_IDLE:  if ((init_left != '0) || owed_pend)    state_nxt = TOP_REQ;
            TOP_REQ:   if (bus_grant)                         state_nxt = TOP_BUSY;
            TOP_BUSY:  if (seq_done)                          state_nxt = TOP_IDLE;
            default:                                          state_nxt = TOP_PAUSE;
        endcase
    end

    // pause, init and cycle-kind bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_cnt <= PW'(INIT_PAUSE - 1);
            init_left <= IW'(INIT_CYCLES);
            is_init   <= 1'b0;
        end else begin
            if ((state == TOP_PAUSE) && (pause_cnt != '0)) begin
                pause_cnt <= pause_cnt - 1'b1;
            end
            if (clk_lapse && (state != TOP_PAUSE)) begin
                init_left <= IW'(INIT_CYCLES);
            end else if (seq_done && is_init && (init_left != '0)) begin
                init_left <= init_left - 1'b1;
            end
            if (start) begin
                is_init <= (init_left != '0);
            end
        end
    end

    // outputs
    always_comb begin
        start     = (state == TOP_REQ) && bus_grant;
        owed_dec  = seq_done && !is_init;
        bus_req   = (state == TOP_REQ) || (state == TOP_BUSY);
        init_done = (state != TOP_PAUSE) && (init_left == '0);
        ras_n     = seq_ras_n;
        we_n      = 1'b1;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign cas_n[g] = seq_cas_n;
    end
endmodule

// File: rtl/drs_checker.sv
`timescale 1ns/1ps
module drs_checker
    import drs_pkg::*;
#(
    parameter int OWED_MAX = 8,
    parameter int LANES    = 2,
    parameter int OW       = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_grant,
    input logic             bus_req,
    input logic             ras_n,
    input logic [LANES-1:0] cas_n,
    input logic             we_n,
    input logic             init_done,
    input logic [1:0]       st,
    input logic [OW-1:0]    owed
);
    a_r2_quiet_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TOP_PAUSE) |-> (!bus_req && ras_n && !init_done));

    a_r3_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (ras_n && !bus_req));

    a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ((cas_n == '0) && ($past(cas_n) == '0)));

    a_r5_we_high: assert property (@(posedge clk) disable iff (!rst_n) we_n);

    a_r6_grant_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n[0]) |-> $past(bus_grant));

    a_r7_release_after_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> (ras_n && $past(ras_n)));

    a_r9_owed_bound: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= OW'(OWED_MAX));
endmodule

bind dram_refresh_sched drs_checker #(
    .OWED_MAX (OWED_MAX), .LANES (LANES), .OW (OW)
) u_chk (
    .clk (clk), .rst_n (rst_n), .bus_grant (bus_grant), .bus_req (bus_req),
    .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .init_done (init_done),
    .st (state), .owed (owed)
);

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
    localparam int PAUSE = 40;
    localparam int RI    = 100;
    localparam int OMAX  = 4;
    localparam int CSR   = 2;
    localparam int CHR   = 2;
    localparam int RAS   = 5;
    localparam int RP    = 3;
    localparam int LN    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_lapse = 1'b0;
    logic bus_grant = 1'b0;
    logic bus_req, ras_n, we_n, init_done;
    logic [LN-1:0] cas_n;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dram_refresh_sched #(
        .INIT_PAUSE (PAUSE), .REF_INTERVAL (RI), .OWED_MAX (OMAX),
        .T_CSR (CSR), .T_CHR (CHR), .T_RAS (RAS), .T_RP (RP), .LANES (LN)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .clk_lapse (clk_lapse), .bus_grant (bus_grant),
        .bus_req (bus_req), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .init_done (init_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // strobe monitor, sampled at the falling edge
    int  cyc = 0, ras_falls = 0, fall_cyc = 0;
    int  cas_run = 0, ras_run = 0, cas_in = 0, pre_run = 0;
    bit  in_pre = 0, prev_ras = 1, prev_req = 0, prev_grant = 0, prev_cas = 1;
    int  we_bad = 0, grant_bad = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (we_n !== 1'b1) we_bad++;
            if (prev_cas && !cas_n[0] && !prev_grant) grant_bad++;
            if (prev_ras && !ras_n) begin
                ras_falls++;
                fall_cyc = cyc;
                chk(cas_run == CSR, "R4 column lead", cas_run, CSR);
                chk(cas_n == '0, "R4 lanes low together", int'(cas_n), 0);
                ras_run = 1;
                cas_in  = (cas_n[0] == 1'b0) ? 1 : 0;
            end else if (!ras_n) begin
                ras_run++;
                if (!cas_n[0]) cas_in++;
            end else if (!prev_ras && ras_n) begin
                chk(ras_run == RAS, "R4 row low width", ras_run, RAS);
                chk(cas_in == CHR, "R4 column hold", cas_in, CHR);
                in_pre  = 1;
                pre_run = 1;
            end else if (in_pre && bus_req) begin
                pre_run++;
            end
            if (in_pre && prev_req && !bus_req) begin
                chk(pre_run == RP, "R7 precharge before release", pre_run, RP);
                in_pre = 0;
            end
            if (ras_n && !cas_n[0]) cas_run++;
            else if (ras_n) cas_run = 0;
        end
        prev_ras   = ras_n;
        prev_cas   = cas_n[0];
        prev_req   = bus_req;
        prev_grant = bus_grant;
    end

    task automatic wait_fall();
        int f0 = ras_falls;
        while (ras_falls == f0) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(ras_n == 1'b1 && cas_n == '1 && we_n == 1'b1, "R1 strobes idle", int'(ras_n), 1);
        chk(bus_req == 1'b0 && init_done == 1'b0, "R1 req/done low", int'(bus_req), 0);
        @(posedge clk); #1 rst_n = 1'b1;
    endtask

    task automatic t_pause();
        int n = 0;
        bus_grant = 1'b1;
        @(negedge clk);
        while (!bus_req) begin
            n++;
            if (init_done) chk(0, "R2 init_done during pause", 1, 0);
            @(negedge clk);
        end
        chk(n >= PAUSE && n <= PAUSE + 3, "R2 pause length", n, PAUSE);
    endtask

    task automatic t_init();
        while (!init_done) @(negedge clk);
        chk(ras_falls == 8, "R3 init refresh count", ras_falls, 8);
        chk(!bus_req && ras_n, "R3 bus released at init_done", int'(bus_req), 0);
    endtask

    task automatic t_period();
        int tp;
        wait_fall();
        tp = fall_cyc;
        for (int i = 0; i < 3; i++) begin
            wait_fall();
            chk(fall_cyc - tp == RI, "R8 refresh spacing", fall_cyc - tp, RI);
            tp = fall_cyc;
        end
    endtask

    task automatic t_starve(input int n, input int exp);
        int f1, f2;
        wait_fall();
        f1 = ras_falls;
        @(posedge clk); #1 bus_grant = 1'b0;
        repeat (n * RI - 2) @(posedge clk);
        #1;
        chk(ras_falls == f1, "R6 no refresh without grant", ras_falls - f1, 0);
        chk(bus_req == 1'b1, "R6 request held while starved", int'(bus_req), 1);
        bus_grant = 1'b1;
        f2 = ras_falls;
        repeat (80) @(negedge clk);
        chk(ras_falls - f2 == exp, "R9 owed refreshes issued", ras_falls - f2, exp);
    endtask

    task automatic t_lapse();
        int f0, c0;
        @(negedge clk);
        while (bus_req) @(negedge clk);
        @(posedge clk); #1 clk_lapse = 1'b1;
        @(posedge clk); #1 clk_lapse = 1'b0;
        f0 = ras_falls;
        c0 = cyc;
        @(negedge clk);
        chk(init_done == 1'b0, "R10 init_done cleared", int'(init_done), 0);
        wait_fall();
        chk(fall_cyc - c0 <= 6, "R10 no pause on re-init", fall_cyc - c0, 6);
        while (!init_done) @(negedge clk);
        chk(ras_falls - f0 == 8, "R10 re-init count", ras_falls - f0, 8);
    endtask

    initial begin
        t_reset();
        t_pause();
        t_init();
        t_period();
        t_starve(3, 3);
        t_starve(6, OMAX);
        t_period();
        t_lapse();
        chk(we_bad == 0, "R5 write enable high", we_bad, 0);
        chk(grant_bad == 0, "R6 strobe only after grant", grant_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 60000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule